// File: doc/BRIEF.md
# Selectable Sine and Square Wave Generator

This block produces a signed 8-bit sample stream with one sample per clock, read from a single phase counter. The counter advances by one on every clock and wraps from its highest value back to zero with no missing step, so one waveform period lasts 256 clocks. A mode input picks one of two outputs. The first is a sine, where the phase addresses a lookup table of signed samples that is computed when the design is elaborated. The second is a square wave, where the phase is compared against a threshold input and the sample takes one of two fixed levels.

The reset input is active low. Asserting it clears the block at once, without waiting for a clock. Its release reaches the logic only through a small local shift register, so every register leaves reset on the same clock edge. A threshold of 128 gives a square wave with a 50 % duty cycle. Other threshold values move the switching point to a different phase.

Top module: `waveGen`

## Requirements
- R1: While `rstN` is low, `sample` is 0. It becomes 0 as soon as `rstN` falls, without waiting for a clock edge.
- R2: After `rstN` rises, `sample` stays 0 over the first four rising clock edges. The fifth rising edge produces the sample for phase 0.
- R3: The phase starts at 0 and advances by exactly one per clock, wrapping from 255 to 0 with no gap. The sample produced at rising edge n after release (n ≥ 5) belongs to phase (n − 5) mod 256.
- R4: With `modeSel` = 1 (sine), the sample from an edge is the sine table entry for the phase held before that edge.
- R5: Sine table entry k is 127·sin(2πk/256) rounded to the nearest integer, with halves rounded away from zero. Entries 0 and 128 are 0, entry 64 is +127, entry 192 is −127, and no entry is −128.
- R6: Every sine entry k + 128 is the negative of entry k, for k from 0 to 127.
- R7: With `modeSel` = 0 (square), the sample is −128 (0x80) when the phase is below `threshold` and +127 (0x7F) when the phase is at or above it.
- R8: In square mode, a threshold of 0 gives +127 at every phase. A threshold of 255 gives +127 only at phase 255.
- R9: A change of `modeSel` takes effect on the next sample and leaves the phase sequence undisturbed.
- R10: Asserting `rstN` while the block is running forces `sample` to 0 at once. After release, the R2 sequence repeats from phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers change on its rising edge |
| rstN | input | 1 | Active-low reset: asserts asynchronously, releases through the local synchroniser |
| modeSel | input | 1 | 1 selects the sine table, 0 selects the square wave |
| threshold | input | 8 | Phase at which the square wave switches from the low level to the high level |
| sample | output | 8 | Signed two's-complement output sample, registered |

## Verification
The assertions assume that `modeSel` and `threshold` are stable around each rising edge. They also assume that `rstN` rises at a point where the four-edge release count is the only thing that paces the restart. The bench therefore changes every input on the falling clock edge, and both releases of reset fall halfway between rising edges. Mid-run reset is the only input change made away from a falling edge. There, only the immediate zero at the output is checked, before the next rising edge arrives.

// File: rtl/waveGenPkg.sv
package waveGenPkg;

  localparam int PHASE_W    = 8;
  localparam int SAMPLE_W   = 8;
  localparam int RST_STAGES = 4;

  localparam int TAB_DEPTH  = 1 << PHASE_W;
  localparam int QUARTER    = TAB_DEPTH / 4;
  localparam int HALF       = TAB_DEPTH / 2;
  localparam int AMP        = (1 << (SAMPLE_W - 1)) - 1;

  localparam logic signed [SAMPLE_W-1:0] LEVEL_HI = SAMPLE_W'(AMP);
  localparam logic signed [SAMPLE_W-1:0] LEVEL_LO = SAMPLE_W'(-(AMP + 1));

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic [PHASE_W-1:0]         phase_t;
  typedef sample_t                    sineTab_t [TAB_DEPTH];

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic   clear;
    phase_t phase;
  } ctrlStrobes_t;

  function automatic int roundAway(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  // Only the first quarter is evaluated; the rest is mirrored so that the
  // odd symmetry of the second half holds exactly.
  function automatic sineTab_t buildSineTab();
    sineTab_t tab;
    real pi2;
    pi2 = 6.283185307179586;
    for (int k = 0; k < TAB_DEPTH; k++) begin
      if (k <= QUARTER)
        tab[k] = SAMPLE_W'(roundAway(real'(AMP) * $sin(pi2 * real'(k) / real'(TAB_DEPTH))));
      else if (k < HALF)
        tab[k] = tab[HALF - k];
      else
        tab[k] = -tab[k - HALF];
    end
    return tab;
  endfunction

endpackage

// File: rtl/waveCtrl.sv
module waveCtrl
  import waveGenPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t strobes
);

  logic [RST_STAGES-1:0] rstPipe;
  logic                  localRst;
  phase_t                phaseCnt;

  // Reset assertion is immediate; release walks a zero down the pipe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPipe <= '1;
    else       rstPipe <= {1'b0, rstPipe[RST_STAGES-1:1]};
  end

  assign localRst = rstPipe[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         phaseCnt <= '0;
    else if (localRst) phaseCnt <= '0;
    else               phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    strobes.clear = localRst;
    strobes.phase = phaseCnt;
  end

endmodule

// File: rtl/waveDatapath.sv
module waveDatapath
  import waveGenPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         modeSel,
  input  phase_t       threshold,
  output sample_t      sample
);

  localparam sineTab_t SINE_TAB = buildSineTab();

  sample_t sineWord;
  sample_t squareWord;
  sample_t nextWord;

  always_comb begin
    sineWord   = SINE_TAB[strobes.phase];
    squareWord = (strobes.phase >= threshold) ? LEVEL_HI : LEVEL_LO;
    nextWord   = modeSel ? sineWord : squareWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sample <= '0;
    else if (strobes.clear) sample <= '0;
    else                    sample <= nextWord;
  end

endmodule

// File: rtl/waveGen.sv
module waveGen
  import waveGenPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       modeSel,
  input  logic [PHASE_W-1:0]         threshold,
  output logic signed [SAMPLE_W-1:0] sample
);

  ctrlStrobes_t strobes;

  waveCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  waveDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .modeSel   (modeSel),
    .threshold (threshold),
    .sample    (sample)
  );

endmodule

// File: rtl/waveGenChk.sv
module waveGenChk
  import waveGenPkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       modeSel,
  input logic [PHASE_W-1:0]         threshold,
  input logic signed [SAMPLE_W-1:0] sample,
  input logic                       clear,
  input logic [PHASE_W-1:0]         phase
);

  p_clear_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (phase == '0 && sample == '0));

  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> (phase == PHASE_W'($past(phase) + 1'b1)));

  p_sine_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && modeSel) |=> (sample != LEVEL_LO));

  p_square_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !modeSel) |=>
      (sample == (($past(phase) >= $past(threshold)) ? LEVEL_HI : LEVEL_LO)));

  p_release_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clear) |-> (phase == '0));

endmodule

bind waveGen waveGenChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .threshold (threshold),
  .sample    (sample),
  .clear     (strobes.clear),
  .phase     (strobes.phase)
);

// File: tb/tb_waveGen.sv
`timescale 1ns/1ps
module tb_waveGen;

  logic              clk = 1'b0;
  logic              rstN;
  logic              modeSel;
  logic [7:0]        threshold;
  logic signed [7:0] sample;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  always #2 clk = ~clk;

  waveGen dut (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .threshold (threshold),
    .sample    (sample)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) edges <= 0;
    else       edges <= edges + 1;
  end

  function automatic int sineRef(int k);
    real x;
    x = 127.0 * $sin(6.283185307179586 * real'(k) / 256.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic int curPhase();
    return (edges - 5) % 256;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runToPhase(int p);
    do tick(); while (!(edges >= 5 && curPhase() == p));
  endtask

  task automatic releaseSequence(string req);
    rstN = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      tick();
      check(req, int'(sample), 0);
    end
    tick();
    check(req, int'(sample), 127);
  endtask

  // Columns: modeSel, threshold, probe phase, expected sample.
  localparam int VEC_N = 20;
  localparam int VEC [VEC_N][4] = '{
    '{1,   0,   0,    0}, '{1,   0,   1,    3}, '{1,   0,  32,   90},
    '{1,   0,  64,  127}, '{1,   0,  96,   90}, '{1,   0, 128,    0},
    '{1,   0, 160,  -90}, '{1,   0, 192, -127}, '{1,   0, 255,   -3},
    '{0, 128,   0, -128}, '{0, 128, 127, -128}, '{0, 128, 128,  127},
    '{0, 128, 255,  127}, '{0, 200, 199, -128}, '{0, 200, 200,  127},
    '{0,   0,   0,  127}, '{0,   0, 100,  127}, '{0, 255, 254, -128},
    '{0, 255, 255,  127}, '{0, 255,   0, -128}
  };

  int seen [256];

  initial begin
    rstN      = 1'b0;
    modeSel   = 1'b0;
    threshold = 8'd0;
    repeat (3) tick();
    check("R1", int'(sample), 0);

    // R2: four zero samples after release, then phase 0 at level +127.
    releaseSequence("R2");

    // Table walk: R4, R5 (sine probes), R7 and R8 (square probes).
    for (int v = 0; v < VEC_N; v++) begin
      modeSel   = VEC[v][0][0];
      threshold = 8'(VEC[v][1]);
      runToPhase(VEC[v][2]);
      check(VEC[v][0] == 1 ? "R4/R5" : (VEC[v][1] == 0 || VEC[v][1] == 255 ? "R8" : "R7"),
            int'(sample), VEC[v][3]);
    end

    // R3: wrap from 255 to 0 with no gap, seen through threshold 255.
    modeSel   = 1'b0;
    threshold = 8'd255;
    runToPhase(254);
    tick(); check("R3", int'(sample), 127);
    tick(); check("R3", int'(sample), -128);

    // R4 / R6 / R5: two full sine periods.
    modeSel = 1'b1;
    for (int i = 0; i < 512; i++) begin
      tick();
      check("R4", int'(sample), sineRef(curPhase()));
      seen[curPhase()] = int'(sample);
    end
    for (int k = 0; k < 128; k++) check("R6", seen[k + 128], -seen[k]);
    begin
      int mx = -1000, mn = 1000;
      for (int k = 0; k < 256; k++) begin
        if (seen[k] > mx) mx = seen[k];
        if (seen[k] < mn) mn = seen[k];
      end
      check("R5", mx, 127);
      check("R5", mn, -127);
      check("R5", seen[0], 0);
      check("R5", seen[128], 0);
    end

    // R9: mode switch on the next sample, phase undisturbed.
    modeSel   = 1'b0;
    threshold = 8'd128;
    runToPhase(10);
    check("R9", int'(sample), -128);
    modeSel = 1'b1;
    tick(); check("R9", int'(sample), sineRef(11));
    modeSel = 1'b0;
    tick(); check("R9", int'(sample), -128);
    modeSel = 1'b1;
    tick(); check("R9", int'(sample), sineRef(13));

    // R10: mid-run reset clears the output without a clock edge.
    runToPhase(64);
    check("R10", int'(sample), 127);
    #0.5 rstN = 1'b0;
    #0.5 check("R10", int'(sample), 0);
    @(negedge clk);
    tick();
    check("R10", int'(sample), 0);
    modeSel   = 1'b0;
    threshold = 8'd0;
    releaseSequence("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule